// File: doc/BRIEF.md
# Sine Waveform Sequencer for a Parallel DAC

This block sits on the host side of a 16-bit parallel digital-to-analog converter that has separate input and output registers. It plays a 256-point sine table to the converter without stopping. A programmable period, counted in clock cycles, paces the samples. For each sample the block places the next table word on the data bus and asserts chip select together with write. It then waits a setup interval, pulses the active-low load strobe, and the rising edge of that pulse moves the word into the converter's output register. The table index advances at that same edge and returns to zero after the last entry.

The write width, setup interval and load pulse widths are set as nanosecond parameters. Each one is turned into a clock-cycle count, rounded up, using the clock period parameter. A sample period shorter than the whole handshake only stretches the interval between samples. When enable is removed, the sample in progress runs to the end, the strobes then rest high, and the index is kept so that streaming carries on from where it stopped.

Top module: `sine_dac_sequencer`

## Requirements
- R1: Table entry i holds 32768 + round(32767 * sin(2*pi*i/256)) as an unsigned offset-binary code masked to 16 bits. Entry 0 is 32768, entry 64 is 65535, entry 192 is 1 and entry 255 is 31964. The first sample after reset is entry 0.
- R2: dacData changes only at the clock edge where the write strobe goes low. It then holds the word until the next write begins.
- R3: csN and wrN are always equal. They go low together for WR cycles (2 at the default parameters) at the start of each sample and are high at all other times.
- R4: ldacN goes low SETUP cycles (2 by default) after write is released and stays low for LOW cycles (5 by default). Its rising edge therefore comes 9 cycles after the data became valid, and it is never low while write is low.
- R5: Between load pulses ldacN stays high for at least HIGH cycles (5 by default), and it rests high whenever no update is in progress.
- R6: Two consecutive samples start max(P, 14) cycles apart, where P is samplePeriod in cycles and 14 is the length of the handshake at the default parameters. P = 0 and P = 3 both give 14, and P = 40 gives 40.
- R7: The index moves forward by one at every load rising edge and wraps from 255 to 0. Sample 256 is entry 0 again and sample 257 is entry 1.
- R8: When enable goes low during a sample, that sample still completes its load pulse. After that no write occurs and all strobes stay high. When enable returns, the next sample uses the entry that follows the last one loaded.
- R9: During reset csN, wrN and ldacN are high and dacData is 0.
- R10: If enable is seen high while the block is idle and at least P cycles have passed since the previous start (always true after reset or a long pause), the write strobe goes low at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows new samples to start |
| samplePeriod | input | 16 | Cycles between sample starts (minimum is the handshake length) |
| dacData | output | 16 | Word driven to the converter's data bus |
| csN | output | 1 | Active-low chip select |
| wrN | output | 1 | Active-low write strobe |
| ldacN | output | 1 | Active-low load strobe; its rising edge commits the word |

## Verification
The case that is hardest to reach from the ports is enable dropping in the middle of a handshake. The load pulse must still finish, no further write may follow, and the index must be kept across the pause. The stimulus waits for a write falling edge and removes enable in the next cycle. After a quiet window it restores enable and compares the word loaded next with the table entry that follows the last committed one. The table wrap is reached by running the shortest period for more than 256 samples and checking samples 255, 256 and 257.

// File: rtl/wave_seq_pkg.sv
package wave_seq_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadSample;   // start of a sample: latch table word, restart period count
    logic advanceIdx;   // load strobe rising: step the table index
  } seqStrb_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_SETUP,
    ST_LDLOW,
    ST_LDHIGH
  } seqState_t;

  // Nanoseconds to clock cycles, rounded up, never below one
  function automatic int cyclesFor(input int nsVal, input int clkPs);
    int c;
    c = (nsVal * 1000 + clkPs - 1) / clkPs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/wave_seq_rom.sv
module wave_seq_rom #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rdData
);

  localparam real PI = 3.14159265358979;

  function automatic logic [DATA_W-1:0] sineCode(input int idx);
    real midV, ampV, angV, valV;
    int  codeV;
    midV  = real'(2 ** (DATA_W - 1));
    ampV  = midV - 1.0;
    angV  = 2.0 * PI * real'(idx) / real'(DEPTH);
    valV  = midV + ampV * $sin(angV);
    codeV = $rtoi(valV + 0.5);
    return DATA_W'(codeV);
  endfunction

  logic [DATA_W-1:0] romArr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    localparam logic [DATA_W-1:0] ENTRY = sineCode(g);
    assign romArr[g] = ENTRY;
  end

  assign rdData = romArr[addr];

endmodule

// File: rtl/wave_seq_datapath.sv
module wave_seq_datapath
  import wave_seq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 256,
  parameter int PERIOD_W = 16,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrb_t            strb,
  input  logic [PERIOD_W-1:0] samplePeriod,
  output logic                periodElapsed,
  output logic [DATA_W-1:0]   dacData
);

  logic [ADDR_W-1:0]   tableIdx;
  logic [DATA_W-1:0]   romWord;
  logic [DATA_W-1:0]   dataReg;
  logic [PERIOD_W-1:0] sinceStart;

  wave_seq_rom #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
  ) u_rom (
    .addr  (tableIdx),
    .rdData(romWord)
  );

  // Table index: steps at each committed sample, wraps at the last entry
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tableIdx <= '0;
    end else if (strb.advanceIdx) begin
      if (tableIdx == ADDR_W'(DEPTH - 1)) tableIdx <= '0;
      else                                tableIdx <= tableIdx + 1'b1;
    end
  end

  // Output word register: changes only when a sample starts
  always_ff @(posedge clk) begin
    if (!rstN)                dataReg <= '0;
    else if (strb.loadSample) dataReg <= romWord & {DATA_W{1'b1}};
  end

  // Cycles since the last sample start, saturating
  always_ff @(posedge clk) begin
    if (!rstN)                       sinceStart <= '1;
    else if (strb.loadSample)        sinceStart <= PERIOD_W'(1);
    else if (sinceStart != '1)       sinceStart <= sinceStart + 1'b1;
  end

  assign periodElapsed = (sinceStart >= samplePeriod);
  assign dacData       = dataReg;

endmodule

// File: rtl/wave_seq_ctrl.sv
module wave_seq_ctrl
  import wave_seq_pkg::*;
#(
  parameter int WR_CYC   = 2,
  parameter int SETUP_CYC = 2,
  parameter int LOW_CYC  = 5,
  parameter int HIGH_CYC = 5,
  localparam int MAX_A   = (WR_CYC > SETUP_CYC) ? WR_CYC : SETUP_CYC,
  localparam int MAX_B   = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC,
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B,
  localparam int PH_W    = $clog2(MAX_CYC + 1)
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     periodElapsed,
  output seqStrb_t strb,
  output logic     csN,
  output logic     wrN,
  output logic     ldacN
);

  seqState_t         state, nState;
  logic [PH_W-1:0]   phaseCnt, nPhaseCnt;
  logic              lastPhase;
  logic              seqDone;
  logic              startNow;

  assign lastPhase = (phaseCnt == '0);
  assign seqDone   = (state == ST_IDLE) || ((state == ST_LDHIGH) && lastPhase);
  assign startNow  = seqDone && enable && periodElapsed;

  always_comb begin
    nState    = state;
    nPhaseCnt = lastPhase ? phaseCnt : phaseCnt - 1'b1;
    unique case (state)
      ST_IDLE: begin
        if (startNow) begin
          nState    = ST_WRITE;
          nPhaseCnt = PH_W'(WR_CYC - 1);
        end
      end
      ST_WRITE: begin
        if (lastPhase) begin
          nState    = ST_SETUP;
          nPhaseCnt = PH_W'(SETUP_CYC - 1);
        end
      end
      ST_SETUP: begin
        if (lastPhase) begin
          nState    = ST_LDLOW;
          nPhaseCnt = PH_W'(LOW_CYC - 1);
        end
      end
      ST_LDLOW: begin
        if (lastPhase) begin
          nState    = ST_LDHIGH;
          nPhaseCnt = PH_W'(HIGH_CYC - 1);
        end
      end
      ST_LDHIGH: begin
        if (startNow) begin
          nState    = ST_WRITE;
          nPhaseCnt = PH_W'(WR_CYC - 1);
        end else if (lastPhase) begin
          nState    = ST_IDLE;
        end
      end
      default: begin
        nState    = ST_IDLE;
        nPhaseCnt = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
    end else begin
      state    <= nState;
      phaseCnt <= nPhaseCnt;
    end
  end

  // Strobes registered from the next state so the pins never glitch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      csN   <= 1'b1;
      wrN   <= 1'b1;
      ldacN <= 1'b1;
    end else begin
      csN   <= (nState != ST_WRITE);
      wrN   <= (nState != ST_WRITE);
      ldacN <= (nState != ST_LDLOW);
    end
  end

  assign strb.loadSample = startNow;
  assign strb.advanceIdx = (state == ST_LDLOW) && lastPhase;

endmodule

// File: rtl/sine_dac_sequencer.sv
module sine_dac_sequencer
  import wave_seq_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int DEPTH        = 256,
  parameter int PERIOD_W     = 16,
  parameter int CLK_PS       = 8000,
  parameter int WR_NS        = 16,
  parameter int SETUP_NS     = 10,
  parameter int LDAC_LOW_NS  = 40,
  parameter int LDAC_HIGH_NS = 40
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic [PERIOD_W-1:0] samplePeriod,
  output logic [DATA_W-1:0]   dacData,
  output logic                csN,
  output logic                wrN,
  output logic                ldacN
);

  localparam int WrCyc    = cyclesFor(WR_NS, CLK_PS);
  localparam int SetupCyc = cyclesFor(SETUP_NS, CLK_PS);
  localparam int LowCyc   = cyclesFor(LDAC_LOW_NS, CLK_PS);
  localparam int HighCyc  = cyclesFor(LDAC_HIGH_NS, CLK_PS);

  seqStrb_t strb;
  logic     periodElapsed;

  wave_seq_ctrl #(
    .WR_CYC   (WrCyc),
    .SETUP_CYC(SetupCyc),
    .LOW_CYC  (LowCyc),
    .HIGH_CYC (HighCyc)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .periodElapsed(periodElapsed),
    .strb         (strb),
    .csN          (csN),
    .wrN          (wrN),
    .ldacN        (ldacN)
  );

  wave_seq_datapath #(
    .DATA_W  (DATA_W),
    .DEPTH   (DEPTH),
    .PERIOD_W(PERIOD_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .samplePeriod (samplePeriod),
    .periodElapsed(periodElapsed),
    .dacData      (dacData)
  );

endmodule

// File: rtl/sine_dac_sequencer_chk.sv
module sine_dac_sequencer_chk
  import wave_seq_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int CLK_PS       = 8000,
  parameter int SETUP_NS     = 10,
  parameter int LDAC_LOW_NS  = 40,
  parameter int LDAC_HIGH_NS = 40
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic [DATA_W-1:0] dacData,
  input logic              csN,
  input logic              wrN,
  input logic              ldacN
);

  localparam int SetupCyc = cyclesFor(SETUP_NS, CLK_PS);
  localparam int LowCyc   = cyclesFor(LDAC_LOW_NS, CLK_PS);
  localparam int HighCyc  = cyclesFor(LDAC_HIGH_NS, CLK_PS);

  logic [7:0] lowRun;
  logic [7:0] highRun;
  logic [7:0] sinceData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowRun    <= '0;
      highRun   <= 8'(HighCyc);
      sinceData <= '0;
    end else begin
      lowRun    <= ldacN ? 8'd0 : ((lowRun == 8'hFF) ? lowRun : lowRun + 1'b1);
      highRun   <= !ldacN ? 8'd0 : ((highRun == 8'hFF) ? highRun : highRun + 1'b1);
      sinceData <= !wrN ? 8'd0 : ((sinceData == 8'hFF) ? sinceData : sinceData + 1'b1);
    end
  end

  // R3
  cs_wr_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN == wrN);

  // R4
  strobe_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!wrN && !ldacN));

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dacData != $past(dacData)) |-> $fell(wrN));

  // R4
  ldac_low_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ldacN) |-> (lowRun >= 8'(LowCyc)));

  // R4
  ldac_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ldacN) |-> (sinceData >= 8'(SetupCyc)));

  // R5
  ldac_high_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ldacN) |-> (highRun >= 8'(HighCyc)));

  // R8
  start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrN) |-> $past(enable));

endmodule

bind sine_dac_sequencer sine_dac_sequencer_chk #(
  .DATA_W      (DATA_W),
  .CLK_PS      (CLK_PS),
  .SETUP_NS    (SETUP_NS),
  .LDAC_LOW_NS (LDAC_LOW_NS),
  .LDAC_HIGH_NS(LDAC_HIGH_NS)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .enable (enable),
  .dacData(dacData),
  .csN    (csN),
  .wrN    (wrN),
  .ldacN  (ldacN)
);

// File: tb/sine_dac_sequencer_tb.sv
`timescale 1ns/1ps
module sine_dac_sequencer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] samplePeriod = 16'd20;
  logic [15:0] dacData;
  logic        csN, wrN, ldacN;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  sine_dac_sequencer u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .samplePeriod(samplePeriod),
    .dacData     (dacData),
    .csN         (csN),
    .wrN         (wrN),
    .ldacN       (ldacN)
  );

  function automatic int sineRef(input int i);
    real a;
    a = 2.0 * 3.14159265358979 * real'(i % 256) / 256.0;
    return $rtoi(32768.0 + 32767.0 * $sin(a) + 0.5) & 16'hFFFF;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Port monitor, sampled at the falling edge
  int cyc = 0, startCount = 0, riseCount = 0;
  int lastStart = 0, lastInterval = 0, lastWrRise = 0;
  int wrRun = 0, ldRun = 0, lastWrLen = 0, lastLow = 0, lastGap = 0;
  int lastSetup = 0, minHigh = 1000, sampleBad = 0, dataBad = 0, csBad = 0;
  logic prevWr = 1'b1, prevLd = 1'b1;
  logic [15:0] prevData = '0;
  int logged [512];

  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (csN !== wrN) csBad++;
      if (dacData !== prevData && !(prevWr && !wrN)) dataBad++;
      if (prevWr && !wrN) begin
        if (startCount > 0) lastInterval = cyc - lastStart;
        lastStart = cyc;
        startCount++;
      end
      if (!prevWr && wrN) begin
        lastWrLen  = wrRun;
        lastWrRise = cyc;
      end
      if (prevLd && !ldacN) begin
        lastGap = cyc - lastWrRise;
        if (riseCount > 0 && ldRun < minHigh) minHigh = ldRun;
      end
      if (!prevLd && ldacN) begin
        lastLow   = ldRun;
        lastSetup = cyc - lastStart;
        if (riseCount < 512) logged[riseCount] = dacData;
        if (int'(dacData) != sineRef(riseCount)) sampleBad++;
        riseCount++;
      end
      wrRun = (wrN == prevWr) ? wrRun + 1 : 1;
      ldRun = (ldacN == prevLd) ? ldRun + 1 : 1;
      prevWr = wrN;
      prevLd = ldacN;
      prevData = dacData;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic waitRises(input int n);
    int target = riseCount + n;
    while (riseCount < target) tick();
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    enable = 1'b0;
    repeat (4) tick();
    check(ldacN === 1'b1 && wrN === 1'b1 && csN === 1'b1, "R9", "strobes in reset",
          {ldacN, wrN, csN}, 7);
    check(dacData === 16'd0, "R9", "data in reset", dacData, 0);
    rstN = 1'b1;
    repeat (30) tick();
    check(startCount == 0 && ldacN === 1'b1, "R5", "idle while disabled", startCount, 0);
  endtask

  task automatic t_basic();
    samplePeriod = 16'd20;
    enable = 1'b1;
    tick();
    check(startCount == 1, "R10", "write one edge after enable", startCount, 1);
    waitRises(4);
    check(logged[0] == 32768, "R1", "first sample", logged[0], 32768);
    check(lastInterval == 20, "R6", "interval P=20", lastInterval, 20);
    check(lastWrLen == 2, "R3", "write low width", lastWrLen, 2);
    check(lastGap == 2, "R4", "write release to load fall", lastGap, 2);
    check(lastLow == 5, "R4", "load low width", lastLow, 5);
    check(lastSetup == 9, "R4", "data valid to load rise", lastSetup, 9);
  endtask

  task automatic t_short_period();
    samplePeriod = 16'd3;
    waitRises(3);
    check(lastInterval == 14, "R6", "interval P=3", lastInterval, 14);
    check(minHigh >= 5, "R5", "load high width", minHigh, 5);
    samplePeriod = 16'd0;
    waitRises(2);
    check(lastInterval == 14, "R6", "interval P=0", lastInterval, 14);
  endtask

  task automatic t_long_period();
    samplePeriod = 16'd40;
    waitRises(3);
    check(lastInterval == 40, "R6", "interval P=40", lastInterval, 40);
  endtask

  task automatic t_wrap();
    samplePeriod = 16'd0;
    while (riseCount < 260) tick();
    check(logged[64] == 65535, "R1", "peak entry", logged[64], 65535);
    check(logged[192] == 1, "R1", "trough entry", logged[192], 1);
    check(logged[255] == 31964, "R1", "last entry", logged[255], 31964);
    check(logged[256] == 32768, "R7", "wrap to entry 0", logged[256], 32768);
    check(logged[257] == 33572, "R7", "entry 1 after wrap", logged[257], 33572);
    check(sampleBad == 0, "R1", "per-sample mismatches", sampleBad, 0);
    check(dataBad == 0, "R2", "data changed outside write", dataBad, 0);
    check(csBad == 0, "R3", "cs differs from wr", csBad, 0);
  endtask

  task automatic t_disable();
    int s0, r0, s1;
    samplePeriod = 16'd0;
    s0 = startCount;
    while (startCount == s0) tick();
    enable = 1'b0;
    r0 = riseCount;
    s1 = startCount;
    repeat (60) tick();
    check(riseCount == r0 + 1, "R8", "sample in flight completes", riseCount, r0 + 1);
    check(startCount == s1, "R8", "no write after disable", startCount, s1);
    check(ldacN === 1'b1 && wrN === 1'b1 && csN === 1'b1, "R8", "strobes idle",
          {ldacN, wrN, csN}, 7);
    enable = 1'b1;
    tick();
    check(startCount == s1 + 1, "R10", "restart after pause", startCount, s1 + 1);
    waitRises(1);
    check(logged[r0 + 1] == sineRef(r0 + 1), "R8", "index kept across pause",
          logged[r0 + 1], sineRef(r0 + 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", riseCount, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_short_period();
    t_long_period();
    t_wrap();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule